// File: doc/BRIEF.md
# Two-Wire Bus Input Deglitch Filter

This block sits between the raw clock and data pins of an SMBus/PMBus target and its protocol logic. It cleans both lines. Each line passes through its own synchronizer. It then goes through a qualification stage that runs on a fast oversampling clock, 200 MHz by default, so one sample is 5 ns. The filtered level flips only when the synchronized input has differed from it for a programmable number of consecutive samples. The default is 12 samples, or 60 ns. Any shorter excursion is discarded. Ground bounce from a switching regulator, ringing on slow edges, and short-pulse traffic from faster bus protocols sharing the wires are all rejected.

A second, independent rule decides when a reversion toward the old level cancels the qualification in progress. A run of reversion samples at least as long as the tolerance parameter clears the qualification count. A shorter run only pauses it. The tolerance defaults to one sample, so every sampled reversion restarts the count. A stream of short pulses separated by brief returns therefore cannot add up to a false edge. Each line also produces one-cycle rise and fall strobes for the protocol logic.

Top module: `tw_deglitch`

## Requirements
- R1: While reset is asserted and on the first cycle after it, both filtered outputs are 1 and all four edge strobes are 0.
- R2: An input excursion that lasts fewer than QUAL_TICKS consecutive samples (11 at the default) leaves the filtered output and the strobes unchanged. An excursion of exactly QUAL_TICKS samples is passed.
- R3: A clean input change that is applied just before clock edge 1 shows on the filtered output after edge QUAL_TICKS+2, which is 2 synchronizer stages plus QUAL_TICKS qualification samples. This holds identically for high-to-low and low-to-high.
- R4: A run of REV_TOL or more consecutive samples back at the old level (1 at the default) clears the qualification progress, so counting restarts from zero.
- R5: A train of pulses at the opposite level, each 10 samples long and separated by 1-sample reversions, never changes the filtered output. This holds from an idle-high line and from a line that is low.
- R6: A non-monotonic edge, where the input crosses back and forth several times before settling, produces exactly one output transition. That transition comes QUAL_TICKS+2 cycles after the final crossing.
- R7: Each output change is accompanied by exactly one strobe, lasting one cycle, in the cycle the new level first appears. The rise strobe goes with a new level of 1 and the fall strobe with a new level of 0. A filtered output never changes without its strobe, and rise and fall are never high together.
- R8: The clock line and the data line are filtered independently. Simultaneous clean changes on both lines give both transitions in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oversampling clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclRaw | input | 1 | Raw asynchronous clock-line level |
| sdaRaw | input | 1 | Raw asynchronous data-line level |
| sclFilt | output | 1 | Filtered clock-line level |
| sdaFilt | output | 1 | Filtered data-line level |
| sclRise | output | 1 | One-cycle strobe: filtered clock line went high |
| sclFall | output | 1 | One-cycle strobe: filtered clock line went low |
| sdaRise | output | 1 | One-cycle strobe: filtered data line went high |
| sdaFall | output | 1 | One-cycle strobe: filtered data line went low |

## Verification
The hardest behaviour to reach is the boundary between an excursion that is rejected and one that is accepted. It only shows when the driven pulse width is exactly right to the sample. The stimulus is therefore driven on the falling clock edge and held for exact sample counts. That places pulses of 11 and 12 samples on either side of the threshold. It also places pulse trains whose combined low time is far beyond the threshold, but whose single-sample reversions must restart the count each time. A non-monotonic edge built from short bursts then checks that only the final settled run produces the single expected transition, at the predicted cycle.

// File: rtl/tw_deglitch_pkg.sv
package tw_deglitch_pkg;

  // Per-line status from datapath to control
  typedef struct packed {
    logic differ;    // synchronized input disagrees with filtered level
    logic qualFull;  // one more differing sample completes qualification
    logic revFull;   // one more reversion sample reaches the tolerance
  } lineStat_t;

  // Per-line strobes from control to datapath
  typedef struct packed {
    logic qualInc;
    logic qualClr;
    logic revInc;
    logic revClr;
    logic flip;
  } lineCtrl_t;

  localparam int unsigned SCL_IDX = 0;
  localparam int unsigned SDA_IDX = 1;

endpackage

// File: rtl/tw_deglitch_ctrl.sv
module tw_deglitch_ctrl
  import tw_deglitch_pkg::*;
#(
  parameter int unsigned NUM_LINES = 2
) (
  input  lineStat_t [NUM_LINES-1:0] stat,
  output lineCtrl_t [NUM_LINES-1:0] ctrl
);

  always_comb begin
    for (int i = 0; i < NUM_LINES; i++) begin
      ctrl[i] = '0;
      if (stat[i].differ) begin
        // new level present: advance qualification, forget reversions
        ctrl[i].revClr = 1'b1;
        if (stat[i].qualFull) begin
          ctrl[i].flip    = 1'b1;
          ctrl[i].qualClr = 1'b1;
        end else begin
          ctrl[i].qualInc = 1'b1;
        end
      end else begin
        // input back at old level: count toward tolerance
        if (stat[i].revFull) begin
          ctrl[i].qualClr = 1'b1;
        end else begin
          ctrl[i].revInc = 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/tw_deglitch_dp.sv
module tw_deglitch_dp
  import tw_deglitch_pkg::*;
#(
  parameter int unsigned NUM_LINES   = 2,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned QUAL_TICKS  = 12,
  parameter int unsigned REV_TOL     = 1
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic      [NUM_LINES-1:0] rawIn,
  input  lineCtrl_t [NUM_LINES-1:0] ctrl,
  output lineStat_t [NUM_LINES-1:0] stat,
  output logic      [NUM_LINES-1:0] filtOut,
  output logic      [NUM_LINES-1:0] riseOut,
  output logic      [NUM_LINES-1:0] fallOut
);

  localparam int unsigned QW = $clog2(QUAL_TICKS + 1);
  localparam int unsigned RW = $clog2(REV_TOL + 1);
  localparam logic [QW-1:0] QUAL_LAST = QW'(QUAL_TICKS - 1);
  localparam logic [RW-1:0] REV_LAST  = RW'(REV_TOL - 1);

  for (genvar g = 0; g < NUM_LINES; g++) begin : gLine
    logic [SYNC_STAGES-1:0] syncSh;
    logic [QW-1:0]          qualCnt;
    logic [RW-1:0]          revCnt;
    logic                   filtQ;
    logic                   riseQ;
    logic                   fallQ;
    lineStat_t              st;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncSh <= '1;
      end else begin
        syncSh <= {syncSh[SYNC_STAGES-2:0], rawIn[g]};
      end
    end

    always_comb begin
      st.differ   = syncSh[SYNC_STAGES-1] != filtQ;
      st.qualFull = qualCnt == QUAL_LAST;
      st.revFull  = revCnt >= REV_LAST;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        qualCnt <= '0;
        revCnt  <= '0;
      end else begin
        if (ctrl[g].qualClr) begin
          qualCnt <= '0;
        end else if (ctrl[g].qualInc) begin
          qualCnt <= qualCnt + 1'b1;
        end
        if (ctrl[g].revClr) begin
          revCnt <= '0;
        end else if (ctrl[g].revInc) begin
          revCnt <= revCnt + 1'b1;
        end
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        filtQ <= 1'b1;
        riseQ <= 1'b0;
        fallQ <= 1'b0;
      end else begin
        if (ctrl[g].flip) begin
          filtQ <= ~filtQ;
        end
        riseQ <= ctrl[g].flip & ~filtQ;
        fallQ <= ctrl[g].flip & filtQ;
      end
    end

    assign stat[g]    = st;
    assign filtOut[g] = filtQ;
    assign riseOut[g] = riseQ;
    assign fallOut[g] = fallQ;
  end

endmodule

// File: rtl/tw_deglitch.sv
module tw_deglitch
  import tw_deglitch_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned QUAL_TICKS  = 12,
  parameter int unsigned REV_TOL     = 1
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclRaw,
  input  logic sdaRaw,
  output logic sclFilt,
  output logic sdaFilt,
  output logic sclRise,
  output logic sclFall,
  output logic sdaRise,
  output logic sdaFall
);

  localparam int unsigned NUM_LINES = 2;

  logic      [NUM_LINES-1:0] rawIn;
  logic      [NUM_LINES-1:0] filtOut;
  logic      [NUM_LINES-1:0] riseOut;
  logic      [NUM_LINES-1:0] fallOut;
  lineStat_t [NUM_LINES-1:0] stat;
  lineCtrl_t [NUM_LINES-1:0] ctrl;

  assign rawIn[SCL_IDX] = sclRaw;
  assign rawIn[SDA_IDX] = sdaRaw;

  tw_deglitch_dp #(
    .NUM_LINES  (NUM_LINES),
    .SYNC_STAGES(SYNC_STAGES),
    .QUAL_TICKS (QUAL_TICKS),
    .REV_TOL    (REV_TOL)
  ) dp_i (
    .clk    (clk),
    .rstN   (rstN),
    .rawIn  (rawIn),
    .ctrl   (ctrl),
    .stat   (stat),
    .filtOut(filtOut),
    .riseOut(riseOut),
    .fallOut(fallOut)
  );

  tw_deglitch_ctrl #(
    .NUM_LINES(NUM_LINES)
  ) ctrl_i (
    .stat(stat),
    .ctrl(ctrl)
  );

  assign sclFilt = filtOut[SCL_IDX];
  assign sdaFilt = filtOut[SDA_IDX];
  assign sclRise = riseOut[SCL_IDX];
  assign sclFall = fallOut[SCL_IDX];
  assign sdaRise = riseOut[SDA_IDX];
  assign sdaFall = fallOut[SDA_IDX];

endmodule

// File: rtl/tw_deglitch_chk.sv
module tw_deglitch_chk (
  input logic clk,
  input logic rstN,
  input logic sclRaw,
  input logic sdaRaw,
  input logic sclFilt,
  input logic sdaFilt,
  input logic sclRise,
  input logic sclFall,
  input logic sdaRise,
  input logic sdaFall
);

  // R7
  scl_change_has_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sclFilt) |-> (sclRise || sclFall));

  // R7
  sda_change_has_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaFilt) |-> (sdaRise || sdaFall));

  // R7
  strobe_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(sclRise && sclFall) && !(sdaRise && sdaFall));

  // R7
  scl_rise_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    sclRise |-> sclFilt);

  // R7
  sda_fall_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    sdaFall |-> !sdaFilt);

  // R7
  scl_strobe_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sclRise || sclFall) |=> !(sclRise || sclFall));

  // R3
  scl_fall_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    sclFall |-> !$past(sclRaw, 3));

  // R3
  sda_rise_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    sdaRise |-> $past(sdaRaw, 3));

endmodule

bind tw_deglitch tw_deglitch_chk chk_i (
  .clk    (clk),
  .rstN   (rstN),
  .sclRaw (sclRaw),
  .sdaRaw (sdaRaw),
  .sclFilt(sclFilt),
  .sdaFilt(sdaFilt),
  .sclRise(sclRise),
  .sclFall(sclFall),
  .sdaRise(sdaRise),
  .sdaFall(sdaFall)
);

// File: tb/tw_deglitch_tb_top.sv
module tw_deglitch_tb_top;

  localparam int QUAL = 12;
  localparam int LAT  = QUAL + 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclRaw = 1'b1;
  logic sdaRaw = 1'b1;
  logic sclFilt, sdaFilt, sclRise, sclFall, sdaRise, sdaFall;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 1'b0;

  typedef struct {
    int    line;
    bit    rising;
    int    when;
    string req;
  } expItem_t;

  expItem_t expQ[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc++;

  tw_deglitch #(.QUAL_TICKS(QUAL), .REV_TOL(1)) dut_i (
    .clk(clk), .rstN(rstN), .sclRaw(sclRaw), .sdaRaw(sdaRaw),
    .sclFilt(sclFilt), .sdaFilt(sdaFilt),
    .sclRise(sclRise), .sclFall(sclFall),
    .sdaRise(sdaRise), .sdaFall(sdaFall)
  );

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // driver helpers: called at a falling edge
  task automatic setLine(int line, bit v);
    if (line == 0) sclRaw = v; else sdaRaw = v;
  endtask

  task automatic hold(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expectEdge(int line, bit rising, string req);
    expItem_t e;
    e.line = line; e.rising = rising; e.when = cyc + LAT; e.req = req;
    expQ.push_back(e);
  endtask

  task automatic burst(int line, bit lvl, int width);
    setLine(line, lvl);
    hold(width);
    setLine(line, ~lvl);
  endtask

  // monitor: pops expected events as strobes appear
  task automatic seen(int line, bit rising, bit level);
    expItem_t e;
    if (expQ.size() == 0) begin
      check(1'b0, "R2", $sformatf("unexpected edge line%0d rising", line), rising, -1);
    end else begin
      e = expQ.pop_front();
      check(e.line == line && e.rising == rising, e.req, "edge line*2+dir",
            line * 2 + rising, e.line * 2 + e.rising);
      check(e.when == cyc, e.req, "edge cycle", cyc, e.when);
      check(level == rising, "R7", "level after strobe", level, rising);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && !done) begin
      if (sclRise) seen(0, 1'b1, sclFilt);
      if (sclFall) seen(0, 1'b0, sclFilt);
      if (sdaRise) seen(1, 1'b1, sdaFilt);
      if (sdaFall) seen(1, 1'b0, sdaFilt);
    end
  end

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "R1", "watchdog expired", 1, 0);
    finishRun();
  end

  initial begin
    hold(3);
    // R1 reset state while asserted
    check(sclFilt && sdaFilt, "R1", "filtered in reset", {sclFilt, sdaFilt}, 3);
    check({sclRise, sclFall, sdaRise, sdaFall} == 4'b0, "R1", "strobes in reset",
          {sclRise, sclFall, sdaRise, sdaFall}, 0);
    rstN = 1'b1;
    hold(1);
    check(sclFilt && sdaFilt, "R1", "filtered after reset", {sclFilt, sdaFilt}, 3);
    check({sclRise, sclFall, sdaRise, sdaFall} == 4'b0, "R1", "strobes after reset",
          {sclRise, sclFall, sdaRise, sdaFall}, 0);
    hold(5);

    // R3 clean fall then clean rise on the clock line
    expectEdge(0, 1'b0, "R3");
    setLine(0, 1'b0);
    hold(30);
    check(sclFilt == 1'b0, "R3", "scl low after fall", sclFilt, 0);
    expectEdge(0, 1'b1, "R3");
    setLine(0, 1'b1);
    hold(30);

    // R2 11-sample burst rejected
    burst(1, 1'b0, QUAL - 1);
    hold(30);
    check(sdaFilt == 1'b1, "R2", "sda after short burst", sdaFilt, 1);

    // R2 exactly QUAL samples passes, then returns
    expectEdge(1, 1'b0, "R2");
    setLine(1, 1'b0);
    hold(QUAL);
    expectEdge(1, 1'b1, "R2");
    setLine(1, 1'b1);
    hold(30);

    // R4 two long runs split by a single reversion sample
    burst(0, 1'b0, 8);
    hold(1);
    burst(0, 1'b0, 8);
    hold(30);
    check(sclFilt == 1'b1, "R4", "scl after split runs", sclFilt, 1);

    // R5 low-going pulse train on an idle-high line
    for (int k = 0; k < 8; k++) begin
      burst(1, 1'b0, 10);
      hold(1);
    end
    hold(30);
    check(sdaFilt == 1'b1, "R5", "sda after low train", sdaFilt, 1);

    // R5 high-going pulse train on a low line
    expectEdge(1, 1'b0, "R5");
    setLine(1, 1'b0);
    hold(30);
    for (int k = 0; k < 8; k++) begin
      burst(1, 1'b1, 10);
      hold(1);
    end
    hold(30);
    check(sdaFilt == 1'b0, "R5", "sda after high train", sdaFilt, 0);
    expectEdge(1, 1'b1, "R5");
    setLine(1, 1'b1);
    hold(30);

    // R6 non-monotonic falling edge
    setLine(0, 1'b0); hold(2);
    setLine(0, 1'b1); hold(1);
    setLine(0, 1'b0); hold(3);
    setLine(0, 1'b1); hold(1);
    expectEdge(0, 1'b0, "R6");
    setLine(0, 1'b0);
    hold(40);
    check(sclFilt == 1'b0, "R6", "scl after ragged fall", sclFilt, 0);

    // R6 non-monotonic rising edge
    setLine(0, 1'b1); hold(4);
    setLine(0, 1'b0); hold(1);
    setLine(0, 1'b1); hold(2);
    setLine(0, 1'b0); hold(1);
    expectEdge(0, 1'b1, "R6");
    setLine(0, 1'b1);
    hold(40);

    // R8 simultaneous changes on both lines
    expectEdge(0, 1'b0, "R8");
    expectEdge(1, 1'b0, "R8");
    setLine(0, 1'b0);
    setLine(1, 1'b0);
    hold(30);
    // R8 noise on one line while the other qualifies
    expectEdge(1, 1'b1, "R8");
    setLine(1, 1'b1);
    burst(0, 1'b1, 5);
    hold(30);
    check(sclFilt == 1'b0, "R8", "scl held during sda edge", sclFilt, 0);
    expectEdge(0, 1'b1, "R8");
    setLine(0, 1'b1);
    hold(40);

    check(expQ.size() == 0, "R3", "expected edges left over", expQ.size(), 0);
    check(sclFilt && sdaFilt, "R7", "final levels", {sclFilt, sdaFilt}, 3);
    finishRun();
  end

endmodule